// File: doc/BRIEF.md
# Observe-Only Boundary Scan Port

This block is the serial test port of a memory device. A four-wire serial interface (clock, mode select, data in, data out) plus an optional active-low asynchronous reset steps a sixteen-state controller. That controller routes a 3-bit instruction register or one of three data registers between the serial input and output. The data registers are a one-bit pass-through stage, a 32-bit identification register and a boundary register of `BSR_LEN` bits. The boundary register takes snapshots of the device's pad inputs and I/O pads.

The port can only observe. It never drives a pad, never loads output buffers and never injects anything into the memory core. Its only effect on the device is `out_hiz`, which asks the memory's output drivers to float while certain instructions are active. Two instructions raise it: the all-zeros instruction, which otherwise behaves like the plain snapshot instruction, and a dedicated snapshot-with-float instruction. The update step of the data-register path does nothing under every instruction.

Top module: `obs_tap`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on each rising edge of `tck` under `tms`. Five consecutive cycles with `tms` high reach Test-Logic-Reset from any state, and an update state left with `tms` low goes to Run-Test/Idle.
- R2: While `trst_n` is low, and on every entry to Test-Logic-Reset, the identification instruction (code 001) becomes the active instruction. At that point `out_hiz` is low and `tdo_en` and `tdo` are low.
- R3: In Capture-IR the instruction shift register loads 001: the two low bits are binary 01 and the top bit is 0. In Shift-IR it shifts toward bit 0, taking `tdi` into bit 2, and `tdo` presents bit 0 first.
- R4: A shifted instruction becomes active only on the clock edge that enters Update-IR. Until then, `out_hiz` and the data path keep following the previous instruction, including through Exit1-IR and Pause-IR.
- R5: Under code 001, Capture-DR loads `ID_VALUE` and Shift-DR sends it out bit 0 first.
- R6: Under code 111 and the reserved codes 011, 101 and 110, the path is a single stage that captures 0. `tdo` repeats `tdi` one shift later, and `out_hiz` stays low.
- R7: Under code 100, Capture-DR copies `pad_snap` into the boundary register. Shift-DR sends it out with `pad_snap[0]` first, and `out_hiz` stays low.
- R8: Code 000 captures and shifts the boundary register exactly as code 100 does, and holds `out_hiz` high while it is the active instruction.
- R9: Code 010 holds `out_hiz` high while it is active, and selects the boundary register for capture and shift.
- R10: Passing through Update-DR changes no register and leaves `out_hiz` and `tdo_en` unchanged under every instruction.
- R11: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high exactly in the half-cycles that follow a rising edge which left the controller in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pad_snap | input | BSR_LEN | Current values of the observed pad inputs and I/O pads |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries valid shift data |
| out_hiz | output | 1 | Request to float the memory's output drivers |

## Verification
The assertions assume that `tms`, `tdi` and `pad_snap` are stable around each rising edge of `tck`. They also assume that `trst_n` is held low before the first edge, so that the controller starts from a known state. The bench changes every input well away from the rising edge, holds `trst_n` low for the first two clocks, and keeps `pad_snap` constant from before Capture-DR until the capture edge has passed. When the bench pulses `trst_n` mid-run, it does so in the low phase of `tck` and keeps it low across a rising edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        S_TLR, S_RTI,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef logic [IR_W-1:0] op_t;

    localparam op_t OP_EXTEST  = 3'b000;
    localparam op_t OP_IDCODE  = 3'b001;
    localparam op_t OP_SAMPLEZ = 3'b010;
    localparam op_t OP_SAMPLE  = 3'b100;
    localparam op_t OP_BYPASS  = 3'b111;
    localparam op_t IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        unique case (s)
            S_TLR:    n = m ? S_TLR    : S_RTI;
            S_RTI:    n = m ? S_SEL_DR : S_RTI;
            S_SEL_DR: n = m ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: n = m ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  n = m ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: n = m ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: n = m ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: n = m ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: n = m ? S_SEL_DR : S_RTI;
            S_SEL_IR: n = m ? S_TLR    : S_CAP_IR;
            S_CAP_IR: n = m ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  n = m ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: n = m ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: n = m ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: n = m ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: n = m ? S_SEL_DR : S_RTI;
            default:  n = S_TLR;
        endcase
        return n;
    endfunction

    function automatic dr_path_e path_of(input op_t op);
        dr_path_e p;
        case (op)
            OP_IDCODE:                        p = PATH_ID;
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: p = PATH_BSR;
            OP_BYPASS:                        p = PATH_BYP;
            default:                          p = PATH_BYP;
        endcase
        return p;
    endfunction

    function automatic logic hiz_of(input op_t op);
        return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
    endfunction

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d
);

    typedef struct packed {
        tap_state_e st;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d    = q;
        d.st = tap_next(q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) q <= '{st: S_TLR};
        else         q <= d;
    end

    assign state_q = q.st;
    assign state_d = d.st;

    // R1
    tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (q.st == S_TLR && tms) |=> (q.st == S_TLR));

    // R1
    upd_exit_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ((q.st == S_UPD_DR || q.st == S_UPD_IR) && !tms) |=> (q.st == S_RTI));

endmodule

// File: rtl/tap_ireg.sv
module tap_ireg
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_q,
    input  tap_state_e state_d,
    output op_t        active,
    output logic       ir_lsb
);

    typedef struct packed {
        op_t sh;
        op_t act;
    } ir_t;

    ir_t q, d;

    always_comb begin
        d = q;
        if (state_q == S_CAP_IR)
            d.sh = IR_CAPTURE;
        else if (state_q == S_SH_IR)
            d.sh = {tdi, q.sh[IR_W-1:1]};

        if (state_d == S_TLR)
            d.act = OP_IDCODE;
        else if (state_d == S_UPD_IR)
            d.act = q.sh;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) q <= '{sh: IR_CAPTURE, act: OP_IDCODE};
        else         q <= d;
    end

    assign active = q.act;
    assign ir_lsb = q.sh[0];

    // R4
    act_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_d != S_UPD_IR && state_d != S_TLR) |=> $stable(q.act));

    // R2
    tlr_id_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == S_TLR) |-> (q.act == OP_IDCODE));

    // R3
    ir_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == S_CAP_IR) |=> (q.sh == IR_CAPTURE));

endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
    import tap_pkg::*;
#(
    parameter int              BSR_LEN  = 16,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h3B2C_60A5
)
(
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state_q,
    input  op_t                active,
    input  logic [BSR_LEN-1:0] pad_snap,
    output logic               dr_lsb
);

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    idr;
        logic [BSR_LEN-1:0] bsr;
    } dr_t;

    dr_t                q, d;
    dr_path_e           path;
    logic               cap, sh;
    logic [BSR_LEN-1:0] bsr_shift;

    generate
        if (BSR_LEN > 1) begin : g_wide
            assign bsr_shift = {tdi, q.bsr[BSR_LEN-1:1]};
        end else begin : g_single
            assign bsr_shift = tdi;
        end
    endgenerate

    assign path = path_of(active);
    assign cap  = (state_q == S_CAP_DR);
    assign sh   = (state_q == S_SH_DR);

    always_comb begin
        d = q;
        unique case (path)
            PATH_ID: begin
                if (cap)     d.idr = ID_VALUE;
                else if (sh) d.idr = {tdi, q.idr[ID_W-1:1]};
            end
            PATH_BSR: begin
                if (cap)     d.bsr = pad_snap;
                else if (sh) d.bsr = bsr_shift;
            end
            default: begin
                if (cap)     d.byp = 1'b0;
                else if (sh) d.byp = tdi;
            end
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) q <= '{byp: 1'b0, idr: ID_VALUE, bsr: '0};
        else         q <= d;
    end

    always_comb begin
        unique case (path)
            PATH_ID:  dr_lsb = q.idr[0];
            PATH_BSR: dr_lsb = q.bsr[0];
            default:  dr_lsb = q.byp;
        endcase
    end

    // R6
    byp_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && path == PATH_BYP) |=> (q.byp == 1'b0));

    // R6
    byp_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sh && path == PATH_BYP) |=> (q.byp == $past(tdi)));

    // R7
    bsr_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && path == PATH_BSR) |=> (q.bsr == $past(pad_snap)));

    // R10
    upd_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == S_UPD_DR) |=> $stable(q));

endmodule

// File: rtl/obs_tap.sv
module obs_tap
    import tap_pkg::*;
#(
    parameter int              BSR_LEN  = 16,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h3B2C_60A5
)
(
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pad_snap,
    output logic               tdo,
    output logic               tdo_en,
    output logic               out_hiz
);

    tap_state_e state_q, state_d;
    op_t        active;
    logic       ir_lsb, dr_lsb;

    tap_ctrl u_ctrl (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state_q),
        .state_d (state_d)
    );

    tap_ireg u_ireg (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state_q (state_q),
        .state_d (state_d),
        .active  (active),
        .ir_lsb  (ir_lsb)
    );

    tap_dregs #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dregs (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state_q  (state_q),
        .active   (active),
        .pad_snap (pad_snap),
        .dr_lsb   (dr_lsb)
    );

    typedef struct packed {
        logic tdo;
        logic en;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d.en  = (state_q == S_SH_IR) || (state_q == S_SH_DR);
        o_d.tdo = 1'b0;
        if (state_q == S_SH_IR)      o_d.tdo = ir_lsb;
        else if (state_q == S_SH_DR) o_d.tdo = dr_lsb;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '{tdo: 1'b0, en: 1'b0};
        else         o_q <= o_d;
    end

    assign tdo     = o_q.tdo;
    assign tdo_en  = o_q.en;
    assign out_hiz = hiz_of(active);

    // R11
    tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == S_SH_IR || state_q == S_SH_DR));

    // R8
    hiz_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_d != S_UPD_IR && state_d != S_TLR) |=> $stable(out_hiz));

endmodule

// File: tb/sim_obs_tap.sv
module sim_obs_tap;

    localparam int          PERIOD = 20;
    localparam int          BSR    = 16;
    localparam logic [31:0] IDV    = 32'h3B2C_60A5;

    // Table row: {opcode[5:3], kind[2:1] (0 bypass, 1 id, 2 boundary), hiz[0]}
    localparam logic [5:0] VEC [8] = '{
        {3'b000, 2'd2, 1'b1},  // R8
        {3'b001, 2'd1, 1'b0},  // R5
        {3'b010, 2'd2, 1'b1},  // R9
        {3'b011, 2'd0, 1'b0},  // R6 reserved
        {3'b100, 2'd2, 1'b0},  // R7
        {3'b101, 2'd0, 1'b0},  // R6 reserved
        {3'b110, 2'd0, 1'b0},  // R6 reserved
        {3'b111, 2'd0, 1'b0}   // R6
    };

    logic           tck = 1'b0;
    logic           trst_n = 1'b0;
    logic           tms = 1'b1;
    logic           tdi = 1'b0;
    logic [BSR-1:0] pads = '0;
    logic           tdo, tdo_en, out_hiz;
    int             checks = 0;
    int             errors = 0;
    bit             done = 1'b0;

    obs_tap #(.BSR_LEN(BSR), .ID_VALUE(IDV)) u0 (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .tdi      (tdi),
        .pad_snap (pads),
        .tdo      (tdo),
        .tdo_en   (tdo_en),
        .out_hiz  (out_hiz)
    );

    always #(PERIOD/2) tck = ~tck;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        #(PERIOD*3/4);
    endtask

    // From a capture state: enter shift, move n bits, end in Exit1.
    task automatic scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n-1, din[i]);
        end
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [31:0] cap);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        scan(3, {29'd0, op}, cap);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic read_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        scan(n, din, dout);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        #(PERIOD*200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, e;
        repeat (2) @(posedge tck);
        #(PERIOD*3/4);
        trst_n = 1'b1;

        // R2 reset state
        chk(out_hiz == 1'b0, "R2 reset out_hiz", out_hiz, 0);
        chk(tdo_en == 1'b0, "R2 reset tdo_en", tdo_en, 0);
        chk(tdo == 1'b0, "R2 reset tdo", tdo, 0);
        step(1'b0, 1'b0);

        // R5 full identification value after reset
        read_dr(32, 32'h0, r);
        chk(r == IDV, "R5 id after reset", r, IDV);

        // R3 captured instruction pattern
        load_ir(3'b001, r);
        chk(r[2:0] == 3'b001, "R3 IR capture", r, 32'h1);

        // Table walk over every opcode
        for (int v = 0; v < 8; v++) begin
            logic [2:0] op;
            logic [1:0] kind;
            logic       hz;
            {op, kind, hz} = VEC[v];
            load_ir(op, r);
            chk(out_hiz == hz, $sformatf("R6-9 hiz op %b", op), out_hiz, hz);
            pads = {8'(v*37 + 5), 8'(v*19 + 106)};
            read_dr(8, 32'hB5, r);
            case (kind)
                2'd1:    e = {24'd0, IDV[7:0]};
                2'd2:    e = {24'd0, pads[7:0]};
                default: e = {24'd0, 8'hB5 << 1} & 32'hFF;
            endcase
            chk(r == e, $sformatf("R5 R6 R7 R8 R9 data op %b", op), r, e);
            chk(out_hiz == hz, $sformatf("R10 hiz after update op %b", op), out_hiz, hz);
        end

        // R4 instruction takes effect only on entering Update-IR
        load_ir(3'b001, r);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        scan(3, 32'h2, r);
        chk(out_hiz == 1'b0, "R4 hiz at Exit1-IR", out_hiz, 0);
        step(1'b0, 1'b0);
        chk(out_hiz == 1'b0, "R4 hiz at Pause-IR", out_hiz, 0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk(out_hiz == 1'b1, "R4 hiz at Update-IR", out_hiz, 1);
        step(1'b0, 1'b0);

        // R9 full boundary register under float-and-sample
        pads = 16'hC3A6;
        read_dr(BSR, 32'h0, r);
        chk(r[BSR-1:0] == 16'hC3A6, "R9 boundary capture", r, 32'hC3A6);

        // R10 Update-DR leaves outputs alone
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        scan(BSR, 32'hFFFF, r);
        step(1'b1, 1'b0);
        chk(out_hiz == 1'b1 && tdo_en == 1'b0, "R10 at Update-DR", {out_hiz, tdo_en}, 32'h2);
        step(1'b0, 1'b0);
        chk(out_hiz == 1'b1, "R10 after Update-DR", out_hiz, 1);

        // R1 five high TMS cycles from Shift-DR reach reset
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        chk(out_hiz == 1'b0, "R1 R2 hiz after TMS reset", out_hiz, 0);
        step(1'b0, 1'b0);
        read_dr(32, 32'h0, r);
        chk(r == IDV, "R1 R2 id after TMS reset", r, IDV);

        // R8 full boundary register under all-zeros code, then async reset
        load_ir(3'b000, r);
        chk(out_hiz == 1'b1, "R8 hiz", out_hiz, 1);
        pads = 16'h5A0F;
        read_dr(BSR, 32'h0, r);
        chk(r[BSR-1:0] == 16'h5A0F, "R8 boundary capture", r, 32'h5A0F);
        trst_n = 1'b0;
        #1;
        chk(out_hiz == 1'b0, "R2 async reset hiz", out_hiz, 0);
        @(posedge tck);
        #(PERIOD*3/4);
        trst_n = 1'b1;
        step(1'b0, 1'b0);

        // R11 falling-edge output timing on the one-bit path
        load_ir(3'b111, r);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk(tdo == 1'b0 && tdo_en == 1'b1, "R11 shift start", {tdo, tdo_en}, 32'h1);
        tdi = 1'b1;
        tms = 1'b0;
        @(posedge tck);
        #(PERIOD/4);
        chk(tdo == 1'b0, "R11 tdo held before fall", tdo, 0);
        #(PERIOD/2);
        chk(tdo == 1'b1, "R11 tdo after fall", tdo, 1);
        step(1'b1, 1'b0);
        chk(tdo_en == 1'b0, "R11 tdo_en off in Exit1-DR", tdo_en, 0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule